// File: doc/BRIEF.md
# UART FIFO Trigger-Level Interrupt Controller

This block holds the transmit and receive byte queues of a serial port, 128 bytes each, and raises one interrupt per direction from the fill level. The receive interrupt tells the host that enough bytes are waiting. The transmit interrupt tells the host that enough free space is left to write a burst. The host writes bytes into the transmit queue and the line-side shifter pops them. The shifter pushes received bytes into the receive queue and the host pops them. Both queues show their oldest entry on the data outputs without waiting for a pop.

Thresholds follow one of two schemes. In the compatible scheme, two 2-bit selectors in the control register pick one of four fixed levels per direction. The block switches to the extended scheme as soon as any of four 8-bit mode registers holds a nonzero value. Those four are flow-high, flow-low, tx-level and rx-level. In the extended scheme each direction's level is its level register's low seven bits plus one, so 128 levels are available. The block returns to the compatible scheme once all four registers are cleared again.

Each direction has its own two-state machine. It starts in `LV_BELOW`, takes the `RAISE` transition to `LV_ABOVE` on the clock edge after the level is met, and takes the `CLEAR` transition back to `LV_BELOW` on the edge after the level is no longer met. The interrupt output is high exactly in `LV_ABOVE`.

Register map (3-bit address). 0 is CTRL: bits [1:0] select the rx level, bits [3:2] select the tx level, bit 4 flushes the rx queue and bit 5 flushes the tx queue. The flush bits are strobes and are not stored. 1 is FLOW_HI, 2 is FLOW_LO, 3 is TX_LVL and 4 is RX_LVL. 5 is STATUS, read-only: bit 0 overrun, bit 1 extended scheme, bit 2 rx interrupt, bit 3 tx interrupt. Reading STATUS clears the overrun bit. 6 is the rx count and 7 is the tx count, both read-only.

Top module: `uart_fifo_trig_ctl`

## Requirements
- R1: Each queue holds up to 128 bytes and returns them in the order they were written. The oldest byte is visible on its data output whenever that queue is not empty.
- R2: After reset both counts read 0, all registers read 0 and STATUS bit 1 is 0 (compatible scheme). Both interrupts are low during reset. The tx interrupt rises on the first clock edge after reset is released.
- R3: In the compatible scheme, CTRL[1:0] sets the rx level: 0 gives 8 entries, 1 gives 16, 2 gives 56 and 3 gives 60.
- R4: In the compatible scheme, CTRL[3:2] sets the tx level in free spaces: 0 gives 8, 1 gives 16, 2 gives 32 and 3 gives 56.
- R5: Any nonzero value in FLOW_HI, FLOW_LO, TX_LVL or RX_LVL selects the extended scheme, and STATUS bit 1 reads 1. In that scheme the rx level is RX_LVL[6:0]+1, the tx level is TX_LVL[6:0]+1, and the CTRL selectors have no effect.
- R6: rx_irq is high on the clock edge after the rx count is at or above the rx level. It falls on the edge after reads bring the count below the level.
- R7: tx_irq is high on the clock edge after the tx free space (128 minus the tx count) is at or above the tx level. It is low one edge after the free space falls below the level.
- R8: A host write to a full tx queue is dropped. The count stays 128 and the stored bytes are unchanged.
- R9: A line push into a full rx queue that is not popped in the same cycle is dropped and sets STATUS bit 0. The bit stays set until STATUS is read. If a new overrun and a STATUS read fall in the same cycle, the bit stays set.
- R10: Writing CTRL with bit 4 or bit 5 set empties the rx or the tx queue in that cycle. The count reads 0 afterwards, a push in the same cycle is discarded, and the flush bits read back as 0.
- R11: A push and a pop in the same cycle on a non-empty queue both take effect and leave the count unchanged. This holds even when the queue is full, and a full rx queue then reports no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (clears overrun on STATUS) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| host_tx_push | input | 1 | Host writes a byte into the tx queue |
| host_tx_data | input | DW | Byte written into the tx queue |
| line_tx_pop | input | 1 | Shifter takes the oldest tx byte |
| line_tx_data | output | DW | Oldest tx byte |
| line_rx_push | input | 1 | Shifter delivers a received byte |
| line_rx_data | input | DW | Received byte |
| host_rx_pop | input | 1 | Host takes the oldest rx byte |
| host_rx_data | output | DW | Oldest rx byte |
| rx_irq | output | 1 | Receive trigger interrupt |
| tx_irq | output | 1 | Transmit trigger interrupt |

## Verification
Two pairs of functions can act in the same clock cycle. The first pair is an overrun and the clearing read of STATUS. The bench provokes it by holding a STATUS read while pushing into a full rx queue, then judges it by a later STATUS read that must still show the overrun. The second pair is a flush and a push in the same cycle. The bench provokes it by writing a flush to CTRL while pushing a byte, then judges it by the count reading zero. The scoreboard then also confirms that the next byte pushed is the first one popped.

// File: rtl/fifo_trig_pkg.sv
package fifo_trig_pkg;

    localparam int unsigned FIFO_DEPTH = 128;
    localparam int unsigned BYTE_W     = 8;

    typedef enum logic [2:0] {
        RA_CTRL    = 3'd0,
        RA_FLOW_HI = 3'd1,
        RA_FLOW_LO = 3'd2,
        RA_TX_LVL  = 3'd3,
        RA_RX_LVL  = 3'd4,
        RA_STATUS  = 3'd5,
        RA_RX_CNT  = 3'd6,
        RA_TX_CNT  = 3'd7
    } reg_addr_e;

    typedef enum logic {
        LV_BELOW = 1'b0,
        LV_ABOVE = 1'b1
    } lvl_state_e;

    // Fixed receive levels of the compatible scheme, in stored entries.
    function automatic int unsigned compat_rx_level(input logic [1:0] sel);
        int unsigned lvl;
        unique case (sel)
            2'd0: lvl = 8;
            2'd1: lvl = 16;
            2'd2: lvl = 56;
            2'd3: lvl = 60;
        endcase
        return lvl;
    endfunction

    // Fixed transmit levels of the compatible scheme, in free spaces.
    function automatic int unsigned compat_tx_level(input logic [1:0] sel);
        int unsigned lvl;
        unique case (sel)
            2'd0: lvl = 8;
            2'd1: lvl = 16;
            2'd2: lvl = 32;
            2'd3: lvl = 56;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/trig_byte_fifo.sv
module trig_byte_fifo #(
    parameter int unsigned DEPTH = 128,
    parameter int unsigned DW    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        flush,
    input  logic                        push,
    input  logic [DW-1:0]               din,
    input  logic                        pop,
    output logic [DW-1:0]               dout,
    output logic [$clog2(DEPTH):0]      count,
    output logic                        drop
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned CW = AW + 1;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;
    logic          full, do_push, do_pop;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign full    = (cnt == CW'(DEPTH));
    assign do_pop  = pop && (cnt != '0);
    assign do_push = push && (!full || do_pop);
    assign drop    = push && !do_push && !flush;
    assign dout    = mem[rd_ptr];
    assign count   = cnt;

    always_ff @(posedge clk) begin
        if (do_push && !flush) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= step(wr_ptr);
            if (do_pop)  rd_ptr <= step(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R1
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0)); // R10
    AST_FULL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> (count == CW'(DEPTH))); // R8
    AST_BOTH_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !flush && (count != '0)) |=> $stable(count)); // R11

endmodule

// File: rtl/lvl_irq_fsm.sv
module lvl_irq_fsm
    import fifo_trig_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic meets,
    output logic irq
);
    lvl_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LV_BELOW;
        else        state_q <= state_d;
    end

    // Transitions: RAISE (LV_BELOW -> LV_ABOVE), CLEAR (LV_ABOVE -> LV_BELOW).
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LV_BELOW: if (meets)  state_d = LV_ABOVE;
            LV_ABOVE: if (!meets) state_d = LV_BELOW;
        endcase
    end

    always_comb begin
        irq = 1'b0;
        unique case (state_q)
            LV_BELOW: irq = 1'b0;
            LV_ABOVE: irq = 1'b1;
        endcase
    end

    AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !meets) |=> !irq); // R6, R7

endmodule

// File: rtl/uart_fifo_trig_ctl.sv
module uart_fifo_trig_ctl
    import fifo_trig_pkg::*;
#(
    parameter int unsigned DEPTH = FIFO_DEPTH,
    parameter int unsigned DW    = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic          reg_re,
    input  logic [2:0]    reg_addr,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    input  logic          host_tx_push,
    input  logic [DW-1:0] host_tx_data,
    input  logic          line_tx_pop,
    output logic [DW-1:0] line_tx_data,
    input  logic          line_rx_push,
    input  logic [DW-1:0] line_rx_data,
    input  logic          host_rx_pop,
    output logic [DW-1:0] host_rx_data,
    output logic          rx_irq,
    output logic          tx_irq
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned CW = AW + 1;

    logic [3:0]    sel_q;
    logic [7:0]    flow_hi_q, flow_lo_q, tx_lvl_q, rx_lvl_q;
    logic          ovr_q;
    logic          ext_mode, wr_ctrl, stat_rd, rx_flush, tx_flush;
    logic          rx_drop, tx_drop, rx_meets, tx_meets;
    logic [CW-1:0] rx_count, tx_count, tx_free, rx_level, tx_level;

    assign ext_mode = |{flow_hi_q, flow_lo_q, tx_lvl_q, rx_lvl_q};
    assign wr_ctrl  = reg_we && (reg_addr == RA_CTRL);
    assign stat_rd  = reg_re && (reg_addr == RA_STATUS);
    assign rx_flush = wr_ctrl && reg_wdata[4];
    assign tx_flush = wr_ctrl && reg_wdata[5];

    // Register writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q     <= '0;
            flow_hi_q <= '0;
            flow_lo_q <= '0;
            tx_lvl_q  <= '0;
            rx_lvl_q  <= '0;
        end else if (reg_we) begin
            unique case (reg_addr_e'(reg_addr))
                RA_CTRL:    sel_q     <= reg_wdata[3:0];
                RA_FLOW_HI: flow_hi_q <= reg_wdata;
                RA_FLOW_LO: flow_lo_q <= reg_wdata;
                RA_TX_LVL:  tx_lvl_q  <= reg_wdata;
                RA_RX_LVL:  rx_lvl_q  <= reg_wdata;
                default:    ;
            endcase
        end
    end

    // Sticky overrun: a new drop wins over the clearing read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ovr_q <= 1'b0;
        else if (rx_drop) ovr_q <= 1'b1;
        else if (stat_rd) ovr_q <= 1'b0;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr_e'(reg_addr))
            RA_CTRL:    reg_rdata = {4'b0000, sel_q};
            RA_FLOW_HI: reg_rdata = flow_hi_q;
            RA_FLOW_LO: reg_rdata = flow_lo_q;
            RA_TX_LVL:  reg_rdata = tx_lvl_q;
            RA_RX_LVL:  reg_rdata = rx_lvl_q;
            RA_STATUS:  reg_rdata = {4'b0000, tx_irq, rx_irq, ext_mode, ovr_q};
            RA_RX_CNT:  reg_rdata = 8'(rx_count);
            RA_TX_CNT:  reg_rdata = 8'(tx_count);
        endcase
    end

    // Threshold selection
    always_comb begin
        if (ext_mode) begin
            rx_level = {{(CW-AW){1'b0}}, rx_lvl_q[AW-1:0]} + CW'(1);
            tx_level = {{(CW-AW){1'b0}}, tx_lvl_q[AW-1:0]} + CW'(1);
        end else begin
            rx_level = CW'(compat_rx_level(sel_q[1:0]));
            tx_level = CW'(compat_tx_level(sel_q[3:2]));
        end
    end

    assign tx_free  = CW'(DEPTH) - tx_count;
    assign rx_meets = (rx_count >= rx_level);
    assign tx_meets = (tx_free >= tx_level);

    trig_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (rx_flush),
        .push  (line_rx_push),
        .din   (line_rx_data),
        .pop   (host_rx_pop),
        .dout  (host_rx_data),
        .count (rx_count),
        .drop  (rx_drop)
    );

    trig_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_tx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (tx_flush),
        .push  (host_tx_push),
        .din   (host_tx_data),
        .pop   (line_tx_pop),
        .dout  (line_tx_data),
        .count (tx_count),
        .drop  (tx_drop)
    );

    lvl_irq_fsm u_rx_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .meets (rx_meets),
        .irq   (rx_irq)
    );

    lvl_irq_fsm u_tx_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .meets (tx_meets),
        .irq   (tx_irq)
    );

    AST_RX_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count >= rx_level) |=> rx_irq); // R6
    AST_TX_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_free >= tx_level) |=> tx_irq); // R7
    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        rx_drop |=> ovr_q); // R9
    AST_TX_DROP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        tx_drop |=> (tx_count == CW'(DEPTH))); // R8

endmodule

// File: tb/sim_uart_fifo_trig_ctl.sv
module sim_uart_fifo_trig_ctl;
    localparam int DEPTH = 128;
    localparam int DW    = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          reg_we, reg_re;
    logic [2:0]    reg_addr;
    logic [7:0]    reg_wdata, reg_rdata;
    logic          host_tx_push, line_tx_pop, line_rx_push, host_rx_pop;
    logic [DW-1:0] host_tx_data, line_tx_data, line_rx_data, host_rx_data;
    logic          rx_irq, tx_irq;

    always #2 clk = ~clk;

    uart_fifo_trig_ctl #(.DEPTH(DEPTH), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .host_tx_push(host_tx_push), .host_tx_data(host_tx_data),
        .line_tx_pop(line_tx_pop), .line_tx_data(line_tx_data),
        .line_rx_push(line_rx_push), .line_rx_data(line_rx_data),
        .host_rx_pop(host_rx_pop), .host_rx_data(host_rx_data),
        .rx_irq(rx_irq), .tx_irq(tx_irq)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    logic [7:0] rxq[$];
    logic [7:0] txq[$];
    logic [7:0] m_ctrl = 0, m_fhi = 0, m_flo = 0, m_txl = 0, m_rxl = 0;
    bit         m_ovr = 0;
    logic [7:0] v;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic bit ext();
        return (m_fhi | m_flo | m_txl | m_rxl) != 0;
    endfunction

    function automatic int rx_lvl();
        if (ext()) return int'(m_rxl & 8'h7f) + 1;
        case (m_ctrl[1:0])
            2'd0: return 8;
            2'd1: return 16;
            2'd2: return 56;
            default: return 60;
        endcase
    endfunction

    function automatic int tx_lvl();
        if (ext()) return int'(m_txl & 8'h7f) + 1;
        case (m_ctrl[3:2])
            2'd0: return 8;
            2'd1: return 16;
            2'd2: return 32;
            default: return 56;
        endcase
    endfunction

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic irq_chk(input string tag);
        cyc();
        chk({tag, " rx_irq"}, int'(rx_irq), int'(rxq.size() >= rx_lvl()));
        chk({tag, " tx_irq"}, int'(tx_irq), int'((DEPTH - txq.size()) >= tx_lvl()));
    endtask

    task automatic wreg(input logic [2:0] a, input logic [7:0] d);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        case (a)
            3'd0: begin
                m_ctrl = {4'b0, d[3:0]};
                if (d[4]) rxq.delete();
                if (d[5]) txq.delete();
            end
            3'd1: m_fhi = d;
            3'd2: m_flo = d;
            3'd3: m_txl = d;
            3'd4: m_rxl = d;
            default: ;
        endcase
        cyc();
        reg_we = 0;
    endtask

    task automatic rreg(input logic [2:0] a, output logic [7:0] val);
        reg_addr = a; reg_re = 1;
        #1 val = reg_rdata;
        cyc();
        reg_re = 0;
        if (a == 3'd5) m_ovr = 0;
    endtask

    // Scoreboard drivers: expected bytes go into the queues
    task automatic rx_in(input logic [7:0] b, input bit with_pop = 0);
        line_rx_push = 1; line_rx_data = b; host_rx_pop = with_pop;
        if (rxq.size() < DEPTH || (with_pop && rxq.size() > 0)) rxq.push_back(b);
        else m_ovr = 1;
        cyc();
        line_rx_push = 0; host_rx_pop = 0;
    endtask

    task automatic host_rd();
        host_rx_pop = 1; cyc(); host_rx_pop = 0;
    endtask

    task automatic tx_wr(input logic [7:0] b);
        host_tx_push = 1; host_tx_data = b;
        if (txq.size() < DEPTH) txq.push_back(b);
        cyc();
        host_tx_push = 0;
    endtask

    task automatic line_tx();
        line_tx_pop = 1; cyc(); line_tx_pop = 0;
    endtask

    // Monitor: compares the oldest byte with the scoreboard head on each pop (R1)
    always @(negedge clk) begin
        if (rst_n === 1'b1 && host_rx_pop && rxq.size() > 0) begin
            chk("R1 rx order", int'(host_rx_data), int'(rxq[0]));
            void'(rxq.pop_front());
        end
        if (rst_n === 1'b1 && line_tx_pop && txq.size() > 0) begin
            chk("R1 tx order", int'(line_tx_data), int'(txq[0]));
            void'(txq.pop_front());
        end
    end

    initial begin
        #400000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog R1..all act=hung exp=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; reg_we = 0; reg_re = 0; reg_addr = 0; reg_wdata = 0;
        host_tx_push = 0; line_tx_pop = 0; line_rx_push = 0; host_rx_pop = 0;
        host_tx_data = 0; line_rx_data = 0;
        repeat (3) cyc();

        // R2 reset state
        chk("R2 rx_irq in reset", int'(rx_irq), 0);
        chk("R2 tx_irq in reset", int'(tx_irq), 0);
        for (int a = 0; a < 8; a++) begin
            rreg(3'(a), v);
            chk("R2 register zero", int'(v), 0);
        end
        rst_n = 1;
        irq_chk("R2 first edge");
        rreg(3'd5, v);
        chk("R2 compat mode", int'(v[1]), 0);

        // R3 compatible rx levels
        for (int i = 0; i < 8; i++) begin rx_in(8'(i * 7 + 3)); irq_chk("R3 sel0"); end
        wreg(3'd0, 8'h01); irq_chk("R3 sel1");
        for (int i = 8; i < 16; i++) begin rx_in(8'(i * 7 + 3)); irq_chk("R3 sel1"); end
        wreg(3'd0, 8'h02); irq_chk("R3 sel2");
        for (int i = 16; i < 56; i++) begin rx_in(8'(i * 7 + 3)); irq_chk("R3 sel2"); end
        wreg(3'd0, 8'h03); irq_chk("R3 sel3");
        for (int i = 56; i < 60; i++) begin rx_in(8'(i * 7 + 3)); irq_chk("R3 sel3"); end
        // R6 clearing by reads
        host_rd(); irq_chk("R6 below level");
        while (rxq.size() > 0) host_rd();
        irq_chk("R6 emptied");

        // R4 / R7 compatible tx levels
        wreg(3'd0, 8'h00);
        for (int i = 0; i < 121; i++) begin
            tx_wr(8'(i * 5 + 1));
            if (i >= 118) irq_chk("R4 sel0");
        end
        wreg(3'd0, 8'h04); irq_chk("R4 sel1");
        while (txq.size() > 112) begin line_tx(); irq_chk("R4 sel1"); end
        wreg(3'd0, 8'h08); irq_chk("R4 sel2");
        while (txq.size() > 96) begin line_tx(); irq_chk("R7 sel2"); end
        wreg(3'd0, 8'h0C); irq_chk("R4 sel3");
        while (txq.size() > 70) begin line_tx(); irq_chk("R7 sel3"); end
        while (txq.size() > 0) line_tx();

        // R8 full tx queue drops writes
        wreg(3'd0, 8'h00);
        for (int i = 0; i < DEPTH; i++) tx_wr(8'(i ^ 8'h5A));
        tx_wr(8'hEE);
        rreg(3'd7, v); chk("R8 count stays full", int'(v), DEPTH);
        irq_chk("R8 full");
        while (txq.size() > 0) line_tx();
        rreg(3'd7, v); chk("R8 drained", int'(v), 0);

        // R9 overrun, R11 push+pop on full
        for (int i = 0; i < DEPTH; i++) rx_in(8'(i + 100));
        rx_in(8'h55);
        rreg(3'd5, v); chk("R9 overrun set", int'(v[0]), 1);
        rreg(3'd5, v); chk("R9 overrun cleared", int'(v[0]), 0);
        rx_in(8'hA5, 1);
        rreg(3'd6, v); chk("R11 count unchanged", int'(v), DEPTH);
        rreg(3'd5, v); chk("R11 no overrun", int'(v[0]), 0);
        reg_addr = 3'd5; reg_re = 1; line_rx_push = 1; line_rx_data = 8'h77;
        cyc();
        reg_re = 0; line_rx_push = 0;
        rreg(3'd5, v); chk("R9 set wins over read", int'(v[0]), 1);
        rreg(3'd5, v); chk("R9 cleared after read", int'(v[0]), 0);
        for (int i = 0; i < 5; i++) host_rd();

        // R10 flushes
        wreg(3'd0, 8'h13);
        rreg(3'd6, v); chk("R10 rx flushed", int'(v), 0);
        rreg(3'd0, v); chk("R10 flush bits not stored", int'(v), 3);
        for (int i = 0; i < 5; i++) tx_wr(8'(i));
        wreg(3'd0, 8'h23);
        rreg(3'd7, v); chk("R10 tx flushed", int'(v), 0);
        reg_we = 1; reg_addr = 3'd0; reg_wdata = 8'h13;
        line_rx_push = 1; line_rx_data = 8'h99;
        cyc();
        reg_we = 0; line_rx_push = 0;
        rreg(3'd6, v); chk("R10 flush beats push", int'(v), 0);
        rx_in(8'h3C); host_rd();
        chk("R1 rx empty after", int'(rxq.size()), 0);

        // R5 extended scheme
        wreg(3'd4, 8'h09);
        rreg(3'd5, v); chk("R5 extended via rx level", int'(v[1]), 1);
        for (int i = 0; i < 10; i++) begin rx_in(8'(i + 40)); irq_chk("R5 rx level 10"); end
        wreg(3'd0, 8'h00); irq_chk("R5 selector ignored");
        wreg(3'd3, 8'h13);
        for (int i = 0; i < 109; i++) tx_wr(8'(i));
        irq_chk("R5 tx free 19");
        line_tx(); irq_chk("R5 tx free 20");
        wreg(3'd4, 8'h00); wreg(3'd3, 8'h00); wreg(3'd2, 8'h01);
        rreg(3'd5, v); chk("R5 extended via flow low", int'(v[1]), 1);
        irq_chk("R5 levels of one");
        wreg(3'd2, 8'h00);
        rreg(3'd5, v); chk("R5 back to compat", int'(v[1]), 0);
        wreg(3'd0, 8'h0F); irq_chk("R5 compat levels again");
        wreg(3'd1, 8'h80);
        rreg(3'd5, v); chk("R5 extended via flow high", int'(v[1]), 1);
        irq_chk("R5 rx level 1");
        wreg(3'd1, 8'h00);
        while (rxq.size() > 0) host_rd();
        while (txq.size() > 0) line_tx();
        irq_chk("R6 R7 final");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule